// File: doc/BRIEF.md
# Corrector Setpoint Combiner

This block forms the DAC setpoint for a bank of corrector power-supply channels. Each channel adds four signed contributions into one code: a slow setting that the host writes through a small register port, a fast feedback setting, a fast compensation setting, and a sample played back from a per-channel waveform store. The sum is clipped to the signed 20-bit range and is driven out in offset-binary form, where mid-scale means zero current. Fast values are written one channel at a time into a staging bank. All staged values reach the outputs together on an external update strobe, which runs at up to 10 kHz.

A trigger starts playback in every enabled channel. The playback pointer moves forward by one on each update strobe. A heartbeat counter, also advanced by the strobe, shows the host that the controller is alive. A one-cycle pulse marks every accepted fast write, so that packet arrival can be timed on a scope. Each channel can be switched off on its own, and each has a sticky overflow flag that the host can clear.

Top module: `cps_setpoint_gen`

## Requirements
- R1: Each enabled channel outputs the offset-binary code of the saturated signed sum of its slow, active feedback, active compensation and current waveform values. The code is the signed value plus 0x80000, so 0x80000 means zero current. The output changes one clock after the state that feeds it changes.
- R2: A register write to address c, for c from 0 to 7, loads wdata[19:0] as the signed slow setting of channel c.
- R3: Sums above 524287 are driven as 524287 (code 0xFFFFF). Sums below -524288 are driven as -524288 (code 0x00000).
- R4: Register address 10 reads the overflow flags, with bit c for channel c. A flag is set whenever its enabled channel clips. It stays set until the host writes a 1 to its bit at address 10. A clear has no effect in a cycle where the channel is still clipping.
- R5: Feedback writes (fb_ch, fb_data) and compensation writes (cp_ch, cp_data) go to a staging bank and have no effect on the outputs until upd_strobe. The strobe moves every staged value to the active bank in one cycle. A write made in the same cycle as the strobe waits for the next strobe.
- R6: Register address 9 reads the 32-bit heartbeat counter. It is 0 after reset, increments by one on each upd_strobe and wraps at 32 bits.
- R7: Register address 8 holds the channel enable mask, with bit c for channel c. It is all ones after reset. A disabled channel outputs 0x80000 and never sets its overflow flag.
- R8: A register write with address bit 7 set stores wdata[19:0] as a signed waveform sample. Address bits 6:4 select the channel and bits 3:0 select the index. wave_trig starts playback at index 0 in every enabled channel. Each upd_strobe advances the index by one. After the last index the channel stops and its waveform contribution is 0. A trigger during playback restarts at index 0 and takes priority over a strobe in the same cycle.
- R9: While a channel is disabled, its playback pointer is held at index 0 and playback is cancelled. Enabling it again does not resume playback; only a new trigger does.
- R10: pkt_pulse is high for exactly the one cycle after each cycle in which fb_wr or cp_wr is asserted.
- R11: After reset every output code is 0x80000, all flags are clear and no playback is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | 8 | Register or waveform address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| fb_wr | input | 1 | Fast feedback staging write |
| fb_ch | input | 3 | Feedback channel select |
| fb_data | input | 20 | Signed feedback value |
| cp_wr | input | 1 | Fast compensation staging write |
| cp_ch | input | 3 | Compensation channel select |
| cp_data | input | 20 | Signed compensation value |
| upd_strobe | input | 1 | One-cycle update strobe (synchronised) |
| wave_trig | input | 1 | One-cycle playback trigger |
| dac_code | output | 160 | Eight 20-bit offset-binary codes, channel c at bits 20c+19:20c |
| pkt_pulse | output | 1 | Fast-write arrival pulse |

## Verification
Every setpoint is registered. A code is therefore due on the first clock edge after the edge that changed its inputs: a slow write, a strobe, a trigger or an enable write. The bench drives each stimulus for one edge, waits one more edge, and only then compares the codes. Register reads are combinational and are sampled in the same low phase in which the address is driven. pkt_pulse is sampled in the low phase right after the write edge. The bench keeps its own model of staged, active and playback state. It updates that model at the edge the stimulus is applied on, so each expected value refers to the right cycle.

// File: rtl/cps_pkg.sv
`timescale 1ns/1ps
package cps_pkg;
    localparam int DAC_W = 20;
    localparam int SUM_W = DAC_W + 2;

    typedef logic signed [DAC_W-1:0] setpt_t;
    typedef logic signed [SUM_W-1:0] sum_t;

    typedef struct packed {
        logic   clip;
        setpt_t val;
    } sat_t;

    localparam logic [DAC_W-1:0] MID_CODE = {1'b1, {(DAC_W-1){1'b0}}};
    localparam sum_t SUM_MAX = {{(SUM_W-DAC_W+1){1'b0}}, {(DAC_W-1){1'b1}}};
    localparam sum_t SUM_MIN = {{(SUM_W-DAC_W+1){1'b1}}, {(DAC_W-1){1'b0}}};

    function automatic sat_t saturate(sum_t s);
        sat_t r;
        if (s > SUM_MAX) begin
            r.clip = 1'b1;
            r.val  = {1'b0, {(DAC_W-1){1'b1}}};
        end else if (s < SUM_MIN) begin
            r.clip = 1'b1;
            r.val  = {1'b1, {(DAC_W-1){1'b0}}};
        end else begin
            r.clip = 1'b0;
            r.val  = s[DAC_W-1:0];
        end
        return r;
    endfunction

    function automatic logic [DAC_W-1:0] to_offset(setpt_t v);
        return {~v[DAC_W-1], v[DAC_W-2:0]};
    endfunction
endpackage

// File: rtl/cps_fast_stage.sv
`timescale 1ns/1ps
module cps_fast_stage
    import cps_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_i,
    input  logic [CHW-1:0] ch_i,
    input  setpt_t         data_i,
    input  logic           strobe_i,
    output setpt_t         act_o [NCH]
);
    setpt_t stage_q [NCH];
    setpt_t act_q   [NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                stage_q[i] <= '0;
                act_q[i]   <= '0;
            end
        end else begin
            if (strobe_i) begin
                for (int i = 0; i < NCH; i++) act_q[i] <= stage_q[i];
            end
            if (wr_i) stage_q[ch_i] <= data_i;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_out
        assign act_o[c] = act_q[c];

        AST_FAST_HOLD: assert property (@(posedge clk) disable iff (rst)
            !strobe_i |=> $stable(act_q[c])); // R5
        AST_FAST_APPLY: assert property (@(posedge clk) disable iff (rst)
            strobe_i |=> act_q[c] == $past(stage_q[c])); // R5
    end
endmodule

// File: rtl/cps_wave_chan.sv
`timescale 1ns/1ps
module cps_wave_chan
    import cps_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          trig_i,
    input  logic          strobe_i,
    input  logic          we_i,
    input  logic [IW-1:0] idx_i,
    input  setpt_t        wdata_i,
    output setpt_t        wave_o
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    setpt_t        mem_q [DEPTH];
    logic [IW-1:0] ptr_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (we_i) mem_q[idx_i] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            ptr_q <= '0;
            run_q <= 1'b0;
        end else if (trig_i) begin
            ptr_q <= '0;
            run_q <= 1'b1;
        end else if (strobe_i && run_q) begin
            if (ptr_q == LAST) begin
                ptr_q <= '0;
                run_q <= 1'b0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    assign wave_o = run_q ? mem_q[ptr_q] : '0;

    AST_PTR_HELD: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (ptr_q == '0) && !run_q); // R9
    AST_TRIG_START: assert property (@(posedge clk) disable iff (rst)
        (en_i && trig_i) |=> run_q && (ptr_q == '0)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> wave_o == '0); // R8
endmodule

// File: rtl/cps_sum_chan.sv
`timescale 1ns/1ps
module cps_sum_chan
    import cps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  setpt_t           slow_i,
    input  setpt_t           fb_i,
    input  setpt_t           cp_i,
    input  setpt_t           wave_i,
    input  logic             clr_i,
    output logic [DAC_W-1:0] code_o,
    output logic             ovf_o
);
    sum_t total;
    sat_t sat;

    assign total = sum_t'(slow_i) + sum_t'(fb_i) + sum_t'(cp_i) + sum_t'(wave_i);
    assign sat   = saturate(total);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o <= MID_CODE;
            ovf_o  <= 1'b0;
        end else begin
            code_o <= en_i ? to_offset(sat.val) : MID_CODE;
            ovf_o  <= (en_i && sat.clip) || (ovf_o && !clr_i);
        end
    end

    AST_DISABLED_MID: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> code_o == MID_CODE); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !clr_i) |=> ovf_o); // R4
    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !ovf_o) |=> !ovf_o); // R7
endmodule

// File: rtl/cps_setpoint_gen.sv
`timescale 1ns/1ps
module cps_setpoint_gen
    import cps_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int WDEPTH = 16,
    parameter int AW     = 8,
    localparam int CHW   = $clog2(NCH),
    localparam int IW    = $clog2(WDEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [AW-1:0]        reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 fb_wr,
    input  logic [CHW-1:0]       fb_ch,
    input  logic [DAC_W-1:0]     fb_data,
    input  logic                 cp_wr,
    input  logic [CHW-1:0]       cp_ch,
    input  logic [DAC_W-1:0]     cp_data,
    input  logic                 upd_strobe,
    input  logic                 wave_trig,
    output logic [NCH*DAC_W-1:0] dac_code,
    output logic                 pkt_pulse
);
    localparam logic [AW-1:0] A_EN  = AW'(NCH);
    localparam logic [AW-1:0] A_HB  = AW'(NCH + 1);
    localparam logic [AW-1:0] A_OVF = AW'(NCH + 2);

    setpt_t           slow_q [NCH];
    logic [NCH-1:0]   en_q;
    logic [31:0]      hb_q;
    logic [NCH-1:0]   ovf_flags;
    logic [NCH-1:0]   ovf_clr;
    setpt_t           fb_act [NCH];
    setpt_t           cp_act [NCH];

    logic             ctl_wr, wave_wr;
    logic [CHW-1:0]   wave_ch;
    logic [IW-1:0]    wave_idx;

    assign ctl_wr   = reg_wr && !reg_addr[AW-1];
    assign wave_wr  = reg_wr &&  reg_addr[AW-1];
    assign wave_ch  = reg_addr[IW +: CHW];
    assign wave_idx = reg_addr[IW-1:0];
    assign ovf_clr  = (ctl_wr && reg_addr == A_OVF) ? reg_wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) slow_q[i] <= '0;
            en_q      <= '1;
            hb_q      <= '0;
            pkt_pulse <= 1'b0;
        end else begin
            if (ctl_wr && reg_addr < A_EN) slow_q[reg_addr[CHW-1:0]] <= reg_wdata[DAC_W-1:0];
            if (ctl_wr && reg_addr == A_EN) en_q <= reg_wdata[NCH-1:0];
            if (upd_strobe) hb_q <= hb_q + 32'd1;
            pkt_pulse <= fb_wr || cp_wr;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_EN:    reg_rdata = 32'(en_q);
            A_HB:    reg_rdata = hb_q;
            A_OVF:   reg_rdata = 32'(ovf_flags);
            default: reg_rdata = '0;
        endcase
    end

    cps_fast_stage #(.NCH(NCH)) u_fb (
        .clk, .rst, .wr_i(fb_wr), .ch_i(fb_ch), .data_i(setpt_t'(fb_data)),
        .strobe_i(upd_strobe), .act_o(fb_act)
    );

    cps_fast_stage #(.NCH(NCH)) u_cp (
        .clk, .rst, .wr_i(cp_wr), .ch_i(cp_ch), .data_i(setpt_t'(cp_data)),
        .strobe_i(upd_strobe), .act_o(cp_act)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        setpt_t           wave_v;
        logic [DAC_W-1:0] code_v;
        logic             ovf_v;

        cps_wave_chan #(.DEPTH(WDEPTH)) u_wave (
            .clk, .rst, .en_i(en_q[c]), .trig_i(wave_trig), .strobe_i(upd_strobe),
            .we_i(wave_wr && wave_ch == CHW'(c)), .idx_i(wave_idx),
            .wdata_i(setpt_t'(reg_wdata[DAC_W-1:0])), .wave_o(wave_v)
        );

        cps_sum_chan u_sum (
            .clk, .rst, .en_i(en_q[c]), .slow_i(slow_q[c]), .fb_i(fb_act[c]),
            .cp_i(cp_act[c]), .wave_i(wave_v), .clr_i(ovf_clr[c]),
            .code_o(code_v), .ovf_o(ovf_v)
        );

        assign dac_code[c*DAC_W +: DAC_W] = code_v;
        assign ovf_flags[c] = ovf_v;
    end

    AST_HB_STEP: assert property (@(posedge clk) disable iff (rst)
        upd_strobe |=> hb_q == $past(hb_q) + 32'd1); // R6
    AST_HB_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd_strobe |=> $stable(hb_q)); // R6
    AST_PKT_PULSE: assert property (@(posedge clk) disable iff (rst)
        (fb_wr || cp_wr) |=> pkt_pulse); // R10
    AST_PKT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(fb_wr || cp_wr) |=> !pkt_pulse); // R10
endmodule

// File: tb/sim_cps_setpoint_gen.sv
`timescale 1ns/1ps
module sim_cps_setpoint_gen;
    localparam int NCH = 8, WD = 16, AW = 8;
    localparam int MID = 1 << 19, VMAX = (1 << 19) - 1, VMIN = -(1 << 19);

    logic clk = 1'b0, rst = 1'b1;
    logic reg_wr = 0; logic [AW-1:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic fb_wr = 0; logic [2:0] fb_ch = 0; logic [19:0] fb_data = 0;
    logic cp_wr = 0; logic [2:0] cp_ch = 0; logic [19:0] cp_data = 0;
    logic upd_strobe = 0, wave_trig = 0;
    logic [NCH*20-1:0] dac_code;
    logic pkt_pulse;

    always #2.5 clk = ~clk;

    cps_setpoint_gen #(.NCH(NCH), .WDEPTH(WD), .AW(AW)) u0 (
        .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .fb_wr, .fb_ch, .fb_data, .cp_wr, .cp_ch, .cp_data,
        .upd_strobe, .wave_trig, .dac_code, .pkt_pulse
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int mslow[NCH], mfb[NCH], mfbs[NCH], mcp[NCH], mcps[NCH], mptr[NCH];
    int mwave[NCH][WD];
    bit mrun[NCH], men[NCH], movf[NCH];
    int mhb = 0;

    function automatic int sx(int v);
        v = v & 32'hFFFFF;
        return (v >= MID) ? v - 2 * MID : v;
    endfunction

    function automatic int raw_sum(int c);
        return mslow[c] + mfb[c] + mcp[c] + (mrun[c] ? mwave[c][mptr[c]] : 0);
    endfunction

    function automatic bit clipped(int c);
        int s = raw_sum(c);
        return men[c] && (s > VMAX || s < VMIN);
    endfunction

    function automatic int exp_code(int c);
        int s;
        if (!men[c]) return MID;
        s = raw_sum(c);
        if (s > VMAX) s = VMAX;
        if (s < VMIN) s = VMIN;
        return s + MID;
    endfunction

    function automatic int ovf_word();
        int w = 0;
        for (int c = 0; c < NCH; c++) if (movf[c]) w |= (1 << c);
        return w;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        for (int c = 0; c < NCH; c++) if (clipped(c)) movf[c] = 1;
        @(negedge clk);
    endtask

    task automatic check_codes(string req);
        for (int c = 0; c < NCH; c++)
            chk(req, $sformatf("code ch%0d", c), longint'(dac_code[c*20 +: 20]), exp_code(c));
    endtask

    task automatic rd(int a, output int d);
        reg_addr = AW'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic do_reg(int a, int d);
        bit old_clip[NCH];
        for (int c = 0; c < NCH; c++) old_clip[c] = clipped(c);
        reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
        @(posedge clk);
        if (a >= 128) mwave[(a >> 4) & 7][a & 15] = sx(d);
        else if (a < NCH) mslow[a] = sx(d);
        else if (a == NCH) begin
            for (int c = 0; c < NCH; c++) begin
                men[c] = d[c];
                if (!men[c]) begin mrun[c] = 0; mptr[c] = 0; end
            end
        end else if (a == NCH + 2) begin
            for (int c = 0; c < NCH; c++)
                movf[c] = (movf[c] && !d[c]) || old_clip[c];
        end
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic do_fast(bit fbw, int fbc, int fbd, bit cpw, int cpc, int cpd, bit stb, bit trg);
        fb_wr = fbw; fb_ch = 3'(fbc); fb_data = 20'(fbd);
        cp_wr = cpw; cp_ch = 3'(cpc); cp_data = 20'(cpd);
        upd_strobe = stb; wave_trig = trg;
        @(posedge clk);
        if (stb) begin
            mhb++;
            for (int c = 0; c < NCH; c++) begin
                mfb[c] = mfbs[c]; mcp[c] = mcps[c];
                if (!trg && mrun[c]) begin
                    if (mptr[c] == WD - 1) begin mrun[c] = 0; mptr[c] = 0; end
                    else mptr[c]++;
                end
            end
        end
        if (fbw) mfbs[fbc] = sx(fbd);
        if (cpw) mcps[cpc] = sx(cpd);
        if (trg) for (int c = 0; c < NCH; c++) if (men[c]) begin mrun[c] = 1; mptr[c] = 0; end
        @(negedge clk);
        chk("R10", "pkt_pulse", longint'(pkt_pulse), longint'(fbw | cpw));
        fb_wr = 0; cp_wr = 0; upd_strobe = 0; wave_trig = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int d;
        int vals[6] = '{1, -1, 12345, -200000, VMAX, VMIN};
        for (int c = 0; c < NCH; c++) begin
            mslow[c] = 0; mfb[c] = 0; mfbs[c] = 0; mcp[c] = 0; mcps[c] = 0;
            mptr[c] = 0; mrun[c] = 0; men[c] = 1; movf[c] = 0;
            for (int i = 0; i < WD; i++) mwave[c][i] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R11 reset state
        check_codes("R11");
        rd(NCH, d);     chk("R7", "enable mask after reset", d, 32'hFF);
        rd(NCH + 1, d); chk("R6", "heartbeat after reset", d, 0);
        rd(NCH + 2, d); chk("R11", "overflow flags after reset", d, 0);

        // R2 slow settings sweep
        foreach (vals[k]) begin
            for (int c = 0; c < NCH; c++) do_reg(c, (c % 2) ? -vals[k] : vals[k]);
            settle();
            check_codes("R2");
        end
        for (int c = 0; c < NCH; c++) do_reg(c, c * 1000 - 3000);
        settle();
        check_codes("R1");

        // R5 staging has no effect before the strobe
        for (int c = 0; c < NCH; c++) do_fast(1, c, 2000 * c + 1, 0, 0, 0, 0, 0);
        for (int c = 0; c < NCH; c++) do_fast(0, 0, 0, 1, c, -777 * c, 0, 0);
        settle();
        check_codes("R5");
        do_fast(0, 0, 0, 0, 0, 0, 1, 0);
        settle();
        check_codes("R1");
        rd(NCH + 1, d); chk("R6", "heartbeat after strobe", d, mhb);

        // R5 write in strobe cycle waits for next strobe
        do_fast(1, 3, 99999, 1, 4, -55555, 1, 0);
        settle();
        check_codes("R5");
        do_fast(0, 0, 0, 0, 0, 0, 1, 0);
        settle();
        check_codes("R5");

        // R6 heartbeat counting
        for (int i = 0; i < 20; i++) do_fast(0, 0, 0, 0, 0, 0, 1, 0);
        rd(NCH + 1, d); chk("R6", "heartbeat count", d, mhb);

        // R3 / R4 saturation and sticky flags
        do_reg(0, VMAX);
        settle(); check_codes("R3");
        rd(NCH + 2, d); chk("R4", "overflow positive clip", d, ovf_word());
        do_fast(0, 0, 0, 1, 1, -300000, 0, 0);
        do_reg(1, VMIN);
        do_fast(0, 0, 0, 0, 0, 0, 1, 0);
        settle(); check_codes("R3");
        rd(NCH + 2, d); chk("R4", "overflow negative clip", d, ovf_word());
        do_reg(0, 0);
        settle(); check_codes("R3");
        rd(NCH + 2, d); chk("R4", "flag sticky after clip ends", d, ovf_word());
        do_reg(NCH + 2, 32'hFF);
        settle();
        rd(NCH + 2, d); chk("R4", "clear while ch1 clips", d, ovf_word());
        chk("R4", "ch1 flag kept", (d >> 1) & 1, 1);
        chk("R4", "ch0 flag cleared", d & 1, 0);

        // R7 disable suppresses output and flag
        do_reg(NCH, 32'hFD);
        do_reg(NCH + 2, 32'h02);
        settle(); check_codes("R7");
        rd(NCH + 2, d); chk("R7", "no flag on disabled clip", d, 0);
        do_reg(1, 0);
        do_reg(NCH, 32'hFF);
        settle(); check_codes("R7");

        // R8 waveform playback
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < WD; i++)
                do_reg(128 + c * 16 + i, ((c + 1) * 3000 + i * 101) * ((i % 2) ? -1 : 1));
        do_reg(NCH, 32'hDF);
        settle(); check_codes("R7");
        do_fast(0, 0, 0, 0, 0, 0, 0, 1);
        settle(); check_codes("R8");
        for (int s = 0; s < WD + 2; s++) begin
            do_fast(0, 0, 0, 0, 0, 0, 1, 0);
            settle(); check_codes("R8");
        end
        // restart in mid-run, trigger wins over strobe
        do_fast(0, 0, 0, 0, 0, 0, 0, 1);
        for (int s = 0; s < 3; s++) do_fast(0, 0, 0, 0, 0, 0, 1, 0);
        settle(); check_codes("R8");
        do_fast(0, 0, 0, 0, 0, 0, 1, 1);
        settle(); check_codes("R8");

        // R9 disable cancels playback, re-enable does not resume
        do_fast(0, 0, 0, 0, 0, 0, 1, 0);
        do_reg(NCH, 32'hDB);
        settle(); check_codes("R9");
        do_reg(NCH, 32'hFF);
        do_fast(0, 0, 0, 0, 0, 0, 1, 0);
        settle(); check_codes("R9");
        chk("R9", "ch2 wave idle after re-enable", longint'(dac_code[2*20 +: 20]), exp_code(2));

        // R10 pulse is one cycle wide
        do_fast(1, 6, 10, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R10", "pkt_pulse falls", longint'(pkt_pulse), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule